// File: doc/BRIEF.md
# Parallel EEPROM Page Writer with Completion Polling

This block is the host side of a parallel EEPROM write. A single start command names a page, a byte count and a completion-detection method. The block then pulls bytes from a valid/ready stream and strobes each byte into the memory with clock-counted write-enable pulses. All bytes go to one page. Only the low column bits of the address advance.

After the last byte, the block waits a fixed gap and then rereads the last written address over and over to learn when the device has finished its internal programming cycle. In data-polling mode, the device returns the complement of the written bit 7 until programming ends. In toggle mode, bit 6 flips on each read until programming ends, so two equal bit-6 reads in a row mean completion. The operation ends in one of three ways:
- a one-cycle `done` pulse on success;
- an underrun flag if the stream stalls longer than the byte-load window;
- a timeout flag if completion is not seen within a set number of status reads.

Top module: `pgwr_poll`

## Requirements
- R1: After reset all three strobes (`mem_ce_n`, `mem_oe_n`, `mem_we_n`) are high, `busy`, `done`, both error flags and `s_ready` are low, and `s_ready` is only ever high while `busy` is high.
- R2: A `start` seen while idle writes `start_len`+1 bytes (`start_len` is the byte count minus one, so 0 means one byte and 255 means 256). The bytes are taken from the stream in order to addresses whose bits 16..8 equal `start_page` and whose bits 7..0 run 0, 1, 2, ...
- R3: Each byte is written with `mem_we_n` and `mem_ce_n` low for exactly WE_LOW cycles, followed by WE_HIGH cycles with `mem_we_n` high. `mem_oe_n` stays high, the data drivers are enabled, and address and data are held steady while `mem_we_n` is low.
- R4: `s_ready` is raised for each byte. If no byte is offered within LOAD_WIN+1 cycles of `s_ready` being high, the block pulses `err_underrun`, goes idle and issues no further write strobes.
- R5: With `start_mode`=0 (data polling), after the last write the block waits POLL_GAP cycles and then reads the last written address with `mem_oe_n` and `mem_ce_n` low for RD_LOW cycles, repeating this gap-and-read pair. Programming is complete on the first read whose bit 7 equals bit 7 of the last written byte.
- R6: With `start_mode`=1 (toggle), the reads are the same as in R5. Programming is complete on the first read whose bit 6 equals bit 6 of the immediately preceding status read of the same operation. Bits 5..0 of status reads are ignored in both modes.
- R7: If POLL_MAX status reads have been made without completion, the block pulses `err_timeout` and goes idle.
- R8: Every accepted operation ends with exactly one one-cycle pulse on exactly one of `done`, `err_underrun`, `err_timeout`. The pulse arrives in the first cycle with `busy` low.
- R9: `start` asserted while `busy` is high is ignored: the page, count and mode of the running operation are unchanged.
- R10: `mem_oe_n` and `mem_we_n` are never low in the same cycle, and the data drivers are disabled during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command, sampled while idle |
| start_page | input | PAGE_W | Page number, placed on address bits 16..8 |
| start_len | input | COL_W | Byte count minus one |
| start_mode | input | 1 | 0 = bit-7 data polling, 1 = bit-6 toggle check |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Block accepts a stream byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | PAGE_W+COL_W | Memory address |
| mem_dout | output | 8 | Write data toward memory |
| mem_doe | output | 1 | Drive enable for write data |
| mem_din | input | 8 | Read data from memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: programming complete |
| err_underrun | output | 1 | One-cycle pulse: stream stalled past the load window |
| err_timeout | output | 1 | One-cycle pulse: completion never seen |

## Verification
A wrong column index or a lost page register shows at once as a byte written to the wrong address. A wrong phase counter shows as a write-enable pulse of the wrong length on its first strobe. A mistake in the status comparison does not show until the end of the operation. It then appears as a read count that differs by one or more from what the bench derives from the memory model's programming length: finishing too early, finishing too late, or reaching the timeout. An error in how the operation ends shows within one cycle as a missing, doubled or wrong outcome pulse, or as `busy` still high.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WLO,
        ST_WHI,
        ST_GAP,
        ST_READ
    } st_e;

    typedef enum logic {
        MODE_DPOLL  = 1'b0,
        MODE_TOGGLE = 1'b1
    } mode_e;
endpackage

// File: rtl/pgwr_cycle_timer.sv
module pgwr_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pgwr_status_eval.sv
module pgwr_status_eval
    import pgwr_pkg::*;
(
    input  mode_e       mode,
    input  logic [1:0]  rd_flags,   // {bit7, bit6} of the status read
    input  logic        wr_b7,
    input  logic        prev_b6,
    input  logic        prev_ok,
    output logic        complete
);
    always_comb begin
        if (mode == MODE_DPOLL) begin
            complete = (rd_flags[1] == wr_b7);
        end else begin
            complete = prev_ok && (rd_flags[0] == prev_b6);
        end
    end
endmodule

// File: rtl/pgwr_poll.sv
module pgwr_poll
    import pgwr_pkg::*;
#(
    parameter int PAGE_W   = 9,
    parameter int COL_W    = 8,
    parameter int WE_LOW   = 4,
    parameter int WE_HIGH  = 4,
    parameter int RD_LOW   = 3,
    parameter int POLL_GAP = 8,
    parameter int LOAD_WIN = 1000,
    parameter int POLL_MAX = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PAGE_W-1:0]       start_page,
    input  logic [COL_W-1:0]        start_len,
    input  logic                    start_mode,
    input  logic                    s_valid,
    input  logic [7:0]              s_data,
    output logic                    s_ready,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [PAGE_W+COL_W-1:0] mem_addr,
    output logic [7:0]              mem_dout,
    output logic                    mem_doe,
    input  logic [7:0]              mem_din,
    output logic                    busy,
    output logic                    done,
    output logic                    err_underrun,
    output logic                    err_timeout
);
    localparam int TW = $clog2(WE_LOW + WE_HIGH + RD_LOW + POLL_GAP + LOAD_WIN + 1);
    localparam int PW = $clog2(POLL_MAX + 1);

    typedef struct packed {
        st_e               st;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  last;
        logic [COL_W-1:0]  idx;
        mode_e             mode;
        logic [7:0]        wdata;
        logic              wr7;
        logic              prev6;
        logic              prev_ok;
        logic [PW-1:0]     polls;
        logic              done;
        logic              eu;
        logic              et;
    } regs_t;

    localparam regs_t RESET_V = '{
        st: ST_IDLE, page: '0, last: '0, idx: '0, mode: MODE_DPOLL,
        wdata: '0, wr7: 1'b0, prev6: 1'b0, prev_ok: 1'b0, polls: '0,
        done: 1'b0, eu: 1'b0, et: 1'b0
    };

    regs_t          r_d, r_q;
    logic           t_load;
    logic [TW-1:0]  t_val;
    logic           t_exp;
    logic           complete;
    logic           unused_rsvd;

    assign unused_rsvd = ^mem_din[5:0];

    pgwr_cycle_timer #(.W(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    pgwr_status_eval eval_i (
        .mode     (r_q.mode),
        .rd_flags (mem_din[7:6]),
        .wr_b7    (r_q.wr7),
        .prev_b6  (r_q.prev6),
        .prev_ok  (r_q.prev_ok),
        .complete (complete)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        r_d.eu   = 1'b0;
        r_d.et   = 1'b0;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_LOAD;
                    r_d.page    = start_page;
                    r_d.last    = start_len;
                    r_d.mode    = mode_e'(start_mode);
                    r_d.idx     = '0;
                    r_d.polls   = '0;
                    r_d.prev_ok = 1'b0;
                    t_load      = 1'b1;
                    t_val       = TW'(LOAD_WIN);
                end
            end
            ST_LOAD: begin
                if (s_valid) begin
                    r_d.wdata = s_data;
                    r_d.st    = ST_WLO;
                    t_load    = 1'b1;
                    t_val     = TW'(WE_LOW - 1);
                end else if (t_exp) begin
                    r_d.eu = 1'b1;
                    r_d.st = ST_IDLE;
                end
            end
            ST_WLO: begin
                if (t_exp) begin
                    r_d.st = ST_WHI;
                    t_load = 1'b1;
                    t_val  = TW'(WE_HIGH - 1);
                end
            end
            ST_WHI: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (r_q.idx == r_q.last) begin
                        r_d.wr7 = r_q.wdata[7];
                        r_d.st  = ST_GAP;
                        t_val   = TW'(POLL_GAP - 1);
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_LOAD;
                        t_val   = TW'(LOAD_WIN);
                    end
                end
            end
            ST_GAP: begin
                if (t_exp) begin
                    r_d.st = ST_READ;
                    t_load = 1'b1;
                    t_val  = TW'(RD_LOW - 1);
                end
            end
            ST_READ: begin
                if (t_exp) begin
                    r_d.prev6   = mem_din[6];
                    r_d.prev_ok = 1'b1;
                    r_d.polls   = r_q.polls + 1'b1;
                    if (complete) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (r_q.polls == PW'(POLL_MAX - 1)) begin
                        r_d.et = 1'b1;
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st = ST_GAP;
                        t_load = 1'b1;
                        t_val  = TW'(POLL_GAP - 1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_V;
        else        r_q <= r_d;
    end

    assign s_ready      = (r_q.st == ST_LOAD);
    assign mem_we_n     = (r_q.st != ST_WLO);
    assign mem_oe_n     = (r_q.st != ST_READ);
    assign mem_ce_n     = !((r_q.st == ST_WLO) || (r_q.st == ST_READ));
    assign mem_doe      = (r_q.st == ST_WLO) || (r_q.st == ST_WHI);
    assign mem_addr     = {r_q.page, r_q.idx};
    assign mem_dout     = r_q.wdata;
    assign busy         = (r_q.st != ST_IDLE);
    assign done         = r_q.done;
    assign err_underrun = r_q.eu;
    assign err_timeout  = r_q.et;
endmodule

// File: rtl/pgwr_poll_chk.sv
module pgwr_poll_chk #(
    parameter int AW     = 17,
    parameter int WE_LOW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_valid,
    input logic          s_ready,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_dout,
    input logic          mem_doe,
    input logic          busy,
    input logic          done,
    input logic          err_underrun,
    input logic          err_timeout
);
    logic [15:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         lo_run <= '0;
        else if (!mem_we_n) lo_run <= lo_run + 16'd1;
        else                lo_run <= '0;
    end

    // R10
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R10
    read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_doe && !mem_ce_n));

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_run == 16'(WE_LOW)));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    // R3
    wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_doe && mem_oe_n));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_underrun || err_timeout) |=> !(done || err_underrun || err_timeout));

    // R8
    end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $onehot({done, err_underrun, err_timeout}));

    // R4
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |-> ($past(s_ready) && !$past(s_valid)));

    // R1
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> busy);
endmodule

bind pgwr_poll pgwr_poll_chk #(.AW(PAGE_W + COL_W), .WE_LOW(WE_LOW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_addr     (mem_addr),
    .mem_dout     (mem_dout),
    .mem_doe      (mem_doe),
    .busy         (busy),
    .done         (done),
    .err_underrun (err_underrun),
    .err_timeout  (err_timeout)
);

// File: tb/pgwr_poll_tb.sv
`timescale 1ns/1ps
module pgwr_poll_tb_top;
    localparam int PAGE_W   = 9;
    localparam int COL_W    = 8;
    localparam int AW       = PAGE_W + COL_W;
    localparam int WE_LOW   = 2;
    localparam int WE_HIGH  = 3;
    localparam int RD_LOW   = 2;
    localparam int POLL_GAP = 3;
    localparam int LOAD_WIN = 4;
    localparam int POLL_MAX = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PAGE_W-1:0] start_page = '0;
    logic [COL_W-1:0]  start_len = '0;
    logic              start_mode = 1'b0;
    logic              s_valid = 1'b0;
    logic [7:0]        s_data = '0;
    logic              s_ready;
    logic              mem_ce_n, mem_oe_n, mem_we_n, mem_doe;
    logic [AW-1:0]     mem_addr;
    logic [7:0]        mem_dout;
    logic [7:0]        mem_din;
    logic              busy, done, err_underrun, err_timeout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    pgwr_poll #(
        .PAGE_W(PAGE_W), .COL_W(COL_W), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH),
        .RD_LOW(RD_LOW), .POLL_GAP(POLL_GAP), .LOAD_WIN(LOAD_WIN), .POLL_MAX(POLL_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
        .start_len(start_len), .start_mode(start_mode), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din), .busy(busy), .done(done), .err_underrun(err_underrun),
        .err_timeout(err_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model
    logic [7:0]    pmem [256];
    logic [7:0]    src  [256];
    bit            model_en = 1'b0;
    int            wr_cnt, reads, addr_err, page_err, width_err, overlap_err;
    int            prog_polls, prog_left, exp_page, lo_cnt;
    logic          tog;
    logic [7:0]    last_wd;
    logic [AW-1:0] last_wa;

    assign mem_din = (prog_left > 0) ? {~last_wd[7], tog, 6'b0} : pmem[mem_addr[7:0]];

    always @(posedge mem_we_n) begin
        if (model_en) begin
            pmem[mem_addr[7:0]] = mem_dout;
            if (int'(mem_addr[AW-1:COL_W]) != exp_page) page_err++;
            wr_cnt++;
            last_wd   = mem_dout;
            last_wa   = mem_addr;
            prog_left = prog_polls;
            tog       = 1'b0;
        end
    end

    always @(posedge mem_oe_n) begin
        if (model_en) begin
            reads++;
            if (mem_addr != last_wa) addr_err++;
            if (prog_left > 0) begin
                prog_left--;
                tog = ~tog;
            end
        end
    end

    always @(negedge clk) begin
        if (model_en) begin
            if (!mem_oe_n && !mem_we_n) overlap_err++;
            if (!mem_we_n) lo_cnt++;
            else if (lo_cnt > 0) begin
                if (lo_cnt != WE_LOW) width_err++;
                lo_cnt = 0;
            end
        end
    end

    // stream driver
    bit drv_en = 1'b0;
    int drv_n, drv_idx, drv_wait, dly_idx, dly_val;

    always @(negedge clk) begin
        if (drv_en && s_ready && drv_idx < drv_n &&
            drv_wait >= ((drv_idx == dly_idx) ? dly_val : 0)) begin
            s_valid = 1'b1;
            s_data  = src[drv_idx];
            drv_idx++;
            drv_wait = 0;
        end else begin
            if (drv_en && s_ready) drv_wait++;
            s_valid = 1'b0;
        end
    end

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 190000);
            summary_and_end();
        end
    end

    task automatic run_op(input int pg, input int nb, input int md, input int pp,
                          input int di, input int dv, input bit ign);
        bit under;
        int exp_wr, need, kind, exp_reads, mism, n, post;
        int done_n, eu_n, et_n, busy_bad;
        bit fin;
        string rtag;
        for (int i = 0; i < 256; i++) begin
            src[i]  = 8'((i * 37 + pg * 11 + nb + md) & 255);
            pmem[i] = 8'h5A;
        end
        wr_cnt = 0; reads = 0; addr_err = 0; page_err = 0; width_err = 0;
        overlap_err = 0; lo_cnt = 0; prog_left = 0;
        exp_page = pg; prog_polls = pp;
        drv_n = nb; drv_idx = 0; drv_wait = 0; dly_idx = di; dly_val = dv;
        drv_en = 1'b1;

        under  = (dv > LOAD_WIN) && (di < nb);
        exp_wr = under ? di : nb;
        if (md == 0) need = pp + 1;
        else if (pp == 0) need = 2;
        else need = (int'(src[nb-1][6]) == ((pp - 1) & 1)) ? pp + 1 : pp + 2;
        if (under) begin kind = 1; exp_reads = 0; end
        else if (need > POLL_MAX) begin kind = 2; exp_reads = POLL_MAX; end
        else begin kind = 0; exp_reads = need; end

        @(negedge clk);
        start = 1'b1; start_page = PAGE_W'(pg); start_len = COL_W'(nb - 1);
        start_mode = md[0];
        @(negedge clk);
        start = 1'b0;
        n = 0; post = 0; fin = 1'b0;
        done_n = 0; eu_n = 0; et_n = 0; busy_bad = 0;
        while (n < 20000 && !(fin && post >= 3)) begin
            @(negedge clk);
            n++;
            if (ign && n == 6 && busy) begin
                start = 1'b1; start_page = PAGE_W'(pg ^ 1); start_len = '0;
                start_mode = ~md[0];
            end else begin
                start = 1'b0;
            end
            if (done) done_n++;
            if (err_underrun) eu_n++;
            if (err_timeout) et_n++;
            if ((done || err_underrun || err_timeout) && busy) busy_bad++;
            if (fin) post++;
            if (done || err_underrun || err_timeout) fin = 1'b1;
        end
        drv_en = 1'b0;
        mism = 0;
        for (int i = 0; i < exp_wr; i++) if (pmem[i] != src[i]) mism++;

        chk(done_n == (kind == 0 ? 1 : 0), "R8 done pulses", done_n, kind == 0 ? 1 : 0);
        chk(eu_n == (kind == 1 ? 1 : 0), "R4 underrun pulses", eu_n, kind == 1 ? 1 : 0);
        chk(et_n == (kind == 2 ? 1 : 0), "R7 timeout pulses", et_n, kind == 2 ? 1 : 0);
        chk(busy_bad == 0 && !busy && !s_ready, "R8 idle at end", busy_bad, 0);
        chk(wr_cnt == exp_wr, ign ? "R9 write count" : "R2 write count", wr_cnt, exp_wr);
        chk(mism == 0, "R2 written bytes", mism, 0);
        chk(page_err == 0, ign ? "R9 page held" : "R2 page bits", page_err, 0);
        chk(width_err == 0, "R3 WE low width", width_err, 0);
        chk(overlap_err == 0, "R10 OE/WE overlap", overlap_err, 0);
        rtag = (kind == 2) ? "R7 status reads" : (md == 1 ? "R6 status reads" : "R5 status reads");
        chk(reads == exp_reads, rtag, reads, exp_reads);
        chk(addr_err == 0, "R5 read address", addr_err, 0);
    endtask

    initial begin
        int pg;
        int nbs [5] = '{1, 2, 3, 5, 256};
        int pps [5] = '{0, 1, 2, 5, 6};
        repeat (3) @(negedge clk);
        chk(mem_we_n && mem_oe_n && mem_ce_n, "R1 strobes in reset", {mem_we_n, mem_oe_n, mem_ce_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err_underrun && !err_timeout && !s_ready,
            "R1 idle after reset", {busy, done, err_underrun, err_timeout, s_ready}, 0);
        chk(mem_we_n && mem_oe_n && mem_ce_n, "R1 strobes after reset",
            {mem_we_n, mem_oe_n, mem_ce_n}, 7);
        model_en = 1'b1;
        pg = 3;
        foreach (nbs[a]) begin
            for (int md = 0; md < 2; md++) begin
                foreach (pps[b]) begin
                    run_op(pg, nbs[a], md, pps[b], 999, 0, 1'b0);
                    pg = (pg * 7 + 5) & 511;
                end
            end
        end
        // R4 boundary: longest accepted stall, then one cycle too long
        run_op(0, 4, 0, 1, 2, LOAD_WIN, 1'b0);
        run_op(511, 4, 1, 1, 2, LOAD_WIN + 1, 1'b0);
        run_op(77, 3, 0, 0, 0, LOAD_WIN + 1, 1'b0);
        run_op(78, 256, 1, 2, 255, LOAD_WIN + 1, 1'b0);
        // R9: start while busy ignored
        run_op(200, 8, 0, 2, 999, 0, 1'b1);
        run_op(201, 8, 1, 3, 999, 0, 1'b1);
        summary_and_end();
    end
endmodule